// File: doc/BRIEF.md
# Bidirectional Port Register Interface

This block is the processor-facing register bank of a 6522-style peripheral adapter. A host reaches it through an 8-bit data bus, a 4-bit register select, a read/write line, two chip selects of opposite polarity and a phase-2 qualifier. Behind that bus sit two 8-bit bidirectional ports, each with a data-direction register, an auxiliary control byte, a peripheral control byte, a shift-register holding byte, and an interrupt flag/enable pair that drives an active-low interrupt request.

Two control inputs, CA1 and CB1, are synchronised into the system clock domain. An active edge of either sets its own interrupt flag. When enabled, that edge also freezes the input value of its port for later reads. The pads themselves are outside this block: it presents the output value and per-line direction of each port and accepts the pin values back. The timer counters, the serial shifting and the CA2/CB2 handshake outputs belong to neighbouring blocks.

The bus is a plain register strobe, so it has no valid/ready handshake. An access is taken on every clock edge at which the qualifying conditions hold. A host issues one access per strobe, and that strobe lasts one clock.

Top module: `pio_regbank`

## Requirements
- R1: An access happens only while `phase2`=1, `cs_hi`=1 and `cs_lo_n`=0. `rw_n`=0 writes and `rw_n`=1 reads. Without a write access no register changes, and without a read access `rdata` is 0.
- R2: Address 3 holds the port A direction byte and address 2 the port B direction byte. Both read back as written and drive `pa_dir`/`pb_dir`. A 1 makes a line an output.
- R3: A read at address 1 or 15 (port A) or address 0 (port B) returns the output register bit where direction=1 and the input value where direction=0. A write at those addresses sets `pa_out`/`pb_out`.
- R4: Address 10 (shift byte), 11 (auxiliary control) and 12 (peripheral control) read back as written. Addresses 4 to 9 read 0 and ignore writes.
- R5: Each of CA1 and CB1 passes through two synchroniser flops. An active edge sets IFR bit 1 (CA1) or bit 4 (CB1). The active edge is chosen by peripheral-control bit 0 (CA1) or bit 4 (CB1): 1 selects rising, 0 selects falling.
- R6: With auxiliary-control bit 0 set, port A input lines read the value captured at the last active CA1 edge. Auxiliary-control bit 1 does the same for port B with CB1. With the bit clear, the live pin value is read.
- R7: A write at address 14 sets the enable bits marked by ones in bits 6:0 when bit 7=1, and clears them when bit 7=0. A read at address 14 returns bit 7 as 1 and the enables in bits 6:0.
- R8: A write at address 13 clears the flags marked by ones. IFR bit 7 reads as the OR of all flags whose enable is set, and `irq_n` is low exactly when that OR is 1.
- R9: Any access at address 1 clears the CA1 flag. An access at address 15 leaves it unchanged.
- R10: Reset clears every register. Both ports become all-input, the outputs go to 0, all flags and enables clear, and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase2 | input | 1 | Bus phase qualifier, access only while high |
| cs_hi | input | 1 | Active-high chip select |
| cs_lo_n | input | 1 | Active-low chip select |
| rw_n | input | 1 | 1 = read, 0 = write |
| rsel | input | 4 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 outside a read access |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output register |
| pa_dir | output | 8 | Port A direction, 1 = output |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output register |
| pb_dir | output | 8 | Port B direction, 1 = output |
| ca1 | input | 1 | Port A control input, asynchronous |
| cb1 | input | 1 | Port B control input, asynchronous |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that `ca1` and `cb1` sit at a defined level at reset release. They also assume that an IFR clear and a new edge event on the same flag are not both intended in one cycle, because the set has priority there. The bench drives every input at the falling clock edge and holds control-line levels at 0 through reset. It waits several cycles after each control-line change so that the synchroniser and edge detector settle before the next strobe. Port pin values are changed only while no active edge is pending, so every capture sees a stable value.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // register select codes; the port A pair and the flag/enable pair are
  // decoded by behaviour, the rest are just storage slots
  localparam logic [3:0] A_PB     = 4'd0;
  localparam logic [3:0] A_PA     = 4'd1;
  localparam logic [3:0] A_DIRB   = 4'd2;
  localparam logic [3:0] A_DIRA   = 4'd3;
  localparam logic [3:0] A_SHIFT  = 4'd10;
  localparam logic [3:0] A_AUX    = 4'd11;
  localparam logic [3:0] A_PCTL   = 4'd12;
  localparam logic [3:0] A_IFLAG  = 4'd13;
  localparam logic [3:0] A_IEN    = 4'd14;
  localparam logic [3:0] A_PA_NH  = 4'd15;
  // flag bit positions inside the interrupt flag byte
  localparam int FLG_CA1 = 1;
  localparam int FLG_CB1 = 4;
  // port slot indices
  localparam int SLOT_B = 0;
  localparam int SLOT_A = 1;
endpackage

// File: rtl/pio_edge_sync.sv
module pio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise_sel,
  output logic evt
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], din};
  end

  always_comb begin
    if (rise_sel) evt = chain[STAGES-1] & ~chain[STAGES];
    else          evt = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_out,
  input  logic          wr_dir,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_in,
  input  logic          latch_en,
  input  logic          cap,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] rd_val
);
  logic [DW-1:0] held;
  logic [DW-1:0] in_src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      held  <= '0;
    end else begin
      if (wr_out) out_q <= wdata;
      if (wr_dir) dir_q <= wdata;
      if (cap)    held  <= pin_in;
    end
  end

  // R3/R6: per-bit mix of driven value and sensed value
  assign in_src = latch_en ? held : pin_in;
  assign rd_val = (out_q & dir_q) | (in_src & ~dir_q);
endmodule

// File: rtl/pio_irq.sv
module pio_irq #(
  parameter int NF = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_v,
  input  logic [NF-1:0] clr_v,
  input  logic          ien_wr,
  input  logic [NF:0]   wdata,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] enables,
  output logic          any
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags   <= '0;
      enables <= '0;
    end else begin
      // a new event wins over a clear in the same cycle
      flags <= (flags & ~clr_v) | set_v;
      if (ien_wr) begin
        if (wdata[NF]) enables <= enables | wdata[NF-1:0];
        else           enables <= enables & ~wdata[NF-1:0];
      end
    end
  end

  assign any = |(flags & enables);
endmodule

// File: rtl/pio_regbank.sv
module pio_regbank #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase2,
  input  logic          cs_hi,
  input  logic          cs_lo_n,
  input  logic          rw_n,
  input  logic [3:0]    rsel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_dir,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_dir,
  input  logic          ca1,
  input  logic          cb1,
  output logic          irq_n
);
  import pio_pkg::*;

  localparam int NF     = DW - 1;
  localparam int NPORTS = 2;

  logic acc, wr, rd;
  logic [DW-1:0] acr_q, pcr_q, shift_q;
  logic [NPORTS-1:0][DW-1:0] pin_v, out_v, dir_v, rdv;
  logic [NPORTS-1:0] line_raw, line_evt, pol, lat_en, wr_out, wr_dir;
  logic [NF-1:0] set_v, clr_v, ifr_q, ier_q;
  logic irq_any;
  logic [DW-1:0] rd_mux;

  // R1: bus qualification
  assign acc = phase2 & cs_hi & ~cs_lo_n;
  assign wr  = acc & ~rw_n;
  assign rd  = acc & rw_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acr_q   <= '0;
      pcr_q   <= '0;
      shift_q <= '0;
    end else if (wr) begin
      if (rsel == A_AUX)   acr_q   <= wdata;
      if (rsel == A_PCTL)  pcr_q   <= wdata;
      if (rsel == A_SHIFT) shift_q <= wdata;
    end
  end

  // slot 0 = port B / CB1, slot 1 = port A / CA1
  assign pin_v    = {pa_in, pb_in};
  assign line_raw = {ca1, cb1};
  assign pol      = {pcr_q[0], pcr_q[4]};
  assign lat_en   = {acr_q[0], acr_q[1]};
  assign wr_out[SLOT_B] = wr & (rsel == A_PB);
  assign wr_out[SLOT_A] = wr & ((rsel == A_PA) | (rsel == A_PA_NH));
  assign wr_dir[SLOT_B] = wr & (rsel == A_DIRB);
  assign wr_dir[SLOT_A] = wr & (rsel == A_DIRA);

  for (genvar gi = 0; gi < NPORTS; gi++) begin : g_slot
    pio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (line_raw[gi]),
      .rise_sel (pol[gi]),
      .evt      (line_evt[gi])
    );
    pio_port #(.DW(DW)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_out   (wr_out[gi]),
      .wr_dir   (wr_dir[gi]),
      .wdata    (wdata),
      .pin_in   (pin_v[gi]),
      .latch_en (lat_en[gi]),
      .cap      (line_evt[gi]),
      .out_q    (out_v[gi]),
      .dir_q    (dir_v[gi]),
      .rd_val   (rdv[gi])
    );
  end

  assign pa_out = out_v[SLOT_A];
  assign pa_dir = dir_v[SLOT_A];
  assign pb_out = out_v[SLOT_B];
  assign pb_dir = dir_v[SLOT_B];

  // R5/R8/R9: flag set and clear sources
  always_comb begin
    set_v = '0;
    set_v[FLG_CA1] = line_evt[SLOT_A];
    set_v[FLG_CB1] = line_evt[SLOT_B];
    clr_v = (wr && rsel == A_IFLAG) ? wdata[NF-1:0] : '0;
    if (acc && rsel == A_PA) clr_v[FLG_CA1] = 1'b1;
  end

  pio_irq #(.NF(NF)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_v   (set_v),
    .clr_v   (clr_v),
    .ien_wr  (wr && rsel == A_IEN),
    .wdata   (wdata),
    .flags   (ifr_q),
    .enables (ier_q),
    .any     (irq_any)
  );

  assign irq_n = ~irq_any;

  // R2/R3/R4/R7/R8 read decode
  always_comb begin
    case (rsel)
      A_PB:             rd_mux = rdv[SLOT_B];
      A_PA, A_PA_NH:    rd_mux = rdv[SLOT_A];
      A_DIRB:           rd_mux = dir_v[SLOT_B];
      A_DIRA:           rd_mux = dir_v[SLOT_A];
      A_SHIFT:          rd_mux = shift_q;
      A_AUX:            rd_mux = acr_q;
      A_PCTL:           rd_mux = pcr_q;
      A_IFLAG:          rd_mux = {irq_any, ifr_q};
      A_IEN:            rd_mux = {1'b1, ier_q};
      default:          rd_mux = '0;
    endcase
    rdata = rd ? rd_mux : '0;
  end
endmodule

// File: rtl/pio_regbank_chk.sv
module pio_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phase2,
  input logic       cs_hi,
  input logic       cs_lo_n,
  input logic       rw_n,
  input logic [3:0] rsel,
  input logic [7:0] wdata,
  input logic [7:0] pa_out,
  input logic [7:0] pa_dir,
  input logic [7:0] pb_out,
  input logic [7:0] pb_dir,
  input logic       irq_n,
  input logic [6:0] ifr_q,
  input logic [1:0] line_evt
);
  logic acc, wr;
  assign acc = phase2 & cs_hi & ~cs_lo_n;
  assign wr  = acc & ~rw_n;

  p_nowrite_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(pa_out) && $stable(pb_out) && $stable(pa_dir) && $stable(pb_dir)));

  p_dira_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rsel == 4'd3) |=> (pa_dir == $past(wdata)));

  p_ca1_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt[1] |=> ifr_q[1]);

  p_ifr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rsel == 4'd13 && wdata[4] && !line_evt[0]) |=> !ifr_q[4]);

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (ifr_q != 7'd0));

  p_pa_access_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rsel == 4'd1 && !line_evt[1]) |=> !ifr_q[1]);

  p_nohs_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rsel == 4'd15 && ifr_q[1]) |=> ifr_q[1]);

  p_reset_state_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> (pa_dir == 8'd0 && pb_dir == 8'd0 && pa_out == 8'd0 && irq_n));
endmodule

bind pio_regbank pio_regbank_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .phase2   (phase2),
  .cs_hi    (cs_hi),
  .cs_lo_n  (cs_lo_n),
  .rw_n     (rw_n),
  .rsel     (rsel),
  .wdata    (wdata),
  .pa_out   (pa_out),
  .pa_dir   (pa_dir),
  .pb_out   (pb_out),
  .pb_dir   (pb_dir),
  .irq_n    (irq_n),
  .ifr_q    (ifr_q),
  .line_evt (line_evt)
);

// File: tb/pio_regbank_test.sv
`timescale 1ns/1ps
module pio_regbank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase2 = 1'b0, cs_hi = 1'b1, cs_lo_n = 1'b0, rw_n = 1'b1;
  logic [3:0] rsel = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata, pa_out, pa_dir, pb_out, pb_dir;
  logic [7:0] pa_in = 8'd0, pb_in = 8'd0;
  logic ca1 = 1'b0, cb1 = 1'b0;
  logic irq_n;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pio_regbank uut (
    .clk(clk), .rst_n(rst_n), .phase2(phase2), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .rw_n(rw_n), .rsel(rsel), .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir),
    .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir),
    .ca1(ca1), .cb1(cb1), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    rsel = a; wdata = d; rw_n = 1'b0; phase2 = 1'b1;
    @(posedge clk); #1;
    phase2 = 1'b0; rw_n = 1'b1;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rsel = a; rw_n = 1'b1; phase2 = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1;
    phase2 = 1'b0;
  endtask

  task automatic set_ca1(input logic v);
    @(negedge clk); ca1 = v; repeat (4) @(posedge clk);
  endtask

  task automatic set_cb1(input logic v);
    @(negedge clk); cb1 = v; repeat (4) @(posedge clk);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk("R10 pa_dir", pa_dir, 8'h00);
    chk("R10 pb_dir", pb_dir, 8'h00);
    chk("R10 pa_out", pa_out, 8'h00);
    chk("R10 irq_n", {7'd0, irq_n}, 8'h01);
    rd_reg(4'd13, v); chk("R10 ifr", v, 8'h00);
    rd_reg(4'd14, v); chk("R10 ier", v, 8'h80);
    rd_reg(4'd11, v); chk("R10 acr", v, 8'h00);

    // R1: unqualified writes have no effect, rdata 0 without read access
    @(negedge clk); rsel = 4'd3; wdata = 8'hFF; rw_n = 1'b0; phase2 = 1'b0;
    @(negedge clk); phase2 = 1'b1; cs_hi = 1'b0;
    @(negedge clk); cs_hi = 1'b1; cs_lo_n = 1'b1;
    @(negedge clk); cs_lo_n = 1'b0; phase2 = 1'b0; rw_n = 1'b1;
    @(negedge clk);
    chk("R1 no write without strobe", pa_dir, 8'h00);
    wr_reg(4'd3, 8'h5A);
    chk("R1 qualified write", pa_dir, 8'h5A);
    @(negedge clk); rsel = 4'd3; rw_n = 1'b1; phase2 = 1'b0; #1;
    chk("R1 rdata idle", rdata, 8'h00);

    // R2/R3: sweep direction and pin patterns on both ports
    wr_reg(4'd1, 8'hC5);
    wr_reg(4'd0, 8'h3A);
    chk("R3 pa_out", pa_out, 8'hC5);
    chk("R3 pb_out", pb_out, 8'h3A);
    for (int d = 0; d < 16; d++) begin
      logic [7:0] dv;
      dv = {d[3:0], d[3:0] ^ 4'hA};
      wr_reg(4'd3, dv);
      wr_reg(4'd2, ~dv);
      chk("R2 pa_dir", pa_dir, dv);
      chk("R2 pb_dir", pb_dir, ~dv);
      rd_reg(4'd2, v); chk("R2 dirb read", v, ~dv);
      for (int p = 0; p < 16; p++) begin
        logic [7:0] pv;
        pv = {p[3:0], ~p[3:0]};
        @(negedge clk); pa_in = pv; pb_in = ~pv;
        rd_reg(4'd15, v); chk("R3 port A mix", v, (8'hC5 & dv) | (pv & ~dv));
        rd_reg(4'd0, v);  chk("R3 port B mix", v, (8'h3A & ~dv) | (~pv & dv));
      end
    end
    wr_reg(4'd3, 8'h00);
    wr_reg(4'd2, 8'h00);

    // R4: storage registers and unused timer slots
    wr_reg(4'd10, 8'h11);
    wr_reg(4'd11, 8'hA4);
    wr_reg(4'd12, 8'hEE);
    for (int a = 4; a < 10; a++) wr_reg(a[3:0], 8'hFF);
    for (int a = 4; a < 15; a++) begin
      logic [7:0] e;
      case (a)
        10: e = 8'h11;
        11: e = 8'hA4;
        12: e = 8'hEE;
        14: e = 8'h80;
        default: e = 8'h00;
      endcase
      rd_reg(a[3:0], v); chk("R4 address sweep", v, e);
    end
    wr_reg(4'd11, 8'h00);
    wr_reg(4'd12, 8'h00);

    // R5: edge polarity selection
    set_ca1(1'b1);
    rd_reg(4'd13, v); chk("R5 CA1 rising ignored when falling selected", v, 8'h00);
    set_ca1(1'b0);
    rd_reg(4'd13, v); chk("R5 CA1 falling sets bit1", v, 8'h02);
    wr_reg(4'd13, 8'h02);
    wr_reg(4'd12, 8'h11);
    set_ca1(1'b1);
    set_cb1(1'b1);
    rd_reg(4'd13, v); chk("R5 rising CA1 and CB1", v, 8'h12);
    set_cb1(1'b0);
    wr_reg(4'd13, 8'h10);
    rd_reg(4'd13, v); chk("R8 clear CB1 only", v, 8'h02);

    // R7: enable set/clear semantics
    wr_reg(4'd14, 8'h82); rd_reg(4'd14, v); chk("R7 set", v, 8'h82);
    wr_reg(4'd14, 8'h90); rd_reg(4'd14, v); chk("R7 set more", v, 8'h92);
    wr_reg(4'd14, 8'h10); rd_reg(4'd14, v); chk("R7 clear", v, 8'h82);

    // R8: irq from enabled flag
    @(negedge clk);
    chk("R8 irq_n low", {7'd0, irq_n}, 8'h00);
    rd_reg(4'd13, v); chk("R8 ifr bit7", v, 8'h82);
    wr_reg(4'd14, 8'h02);
    @(negedge clk);
    chk("R8 irq_n high when disabled", {7'd0, irq_n}, 8'h01);
    rd_reg(4'd13, v); chk("R8 ifr no bit7", v, 8'h02);

    // R9: alias address keeps flag, primary clears it
    rd_reg(4'd15, v);
    rd_reg(4'd13, v); chk("R9 addr 15 keeps CA1", v, 8'h02);
    rd_reg(4'd1, v);
    rd_reg(4'd13, v); chk("R9 addr 1 read clears CA1", v, 8'h00);
    set_ca1(1'b0); set_ca1(1'b1);
    wr_reg(4'd1, 8'h00);
    rd_reg(4'd13, v); chk("R9 addr 1 write clears CA1", v, 8'h00);

    // R6: input latching on active edge
    wr_reg(4'd11, 8'h03);
    set_ca1(1'b0);
    @(negedge clk); pa_in = 8'h3C; pb_in = 8'h96;
    set_ca1(1'b1);
    set_cb1(1'b1);
    @(negedge clk); pa_in = 8'hC3; pb_in = 8'h69;
    rd_reg(4'd15, v); chk("R6 port A latched", v, 8'h3C);
    rd_reg(4'd0, v);  chk("R6 port B latched", v, 8'h96);
    wr_reg(4'd11, 8'h00);
    rd_reg(4'd15, v); chk("R6 port A live", v, 8'hC3);
    rd_reg(4'd0, v);  chk("R6 port B live", v, 8'h69);

    finish_run();
  end
endmodule